// File: doc/BRIEF.md
# Cascaded Biquad Low-Pass Interpolator

This block takes signed samples from a slow analog-to-digital converter, each marked by a one-cycle valid strobe, and produces a smoothed signed stream at a much faster, fixed frame rate. The newest input sample is held constant between strobes (zero-order hold). At every frame tick it feeds a fourth-order low-pass IIR filter. The filter is built as two second-order sections in direct form I. With a 200 MHz fast clock and `DIV = 10`, frames arrive at 20 MHz and the default coefficients place the corner near the low hundreds of kHz. The wanted band of 0 to 200 kHz passes with unity DC gain, while the staircase edges of the hold are smoothed away.

To keep area small, each section owns a single multiplier and a single accumulator. Over five fast cycles per frame, the section steps through its five taps in a fixed order. Products are summed at full width and rounded only once, at the section output, into a state word that carries guard fraction bits below the integer sample. The final output is rounded back to integer units and saturated to 16 bits. The coefficients are fixed-point integer parameters with `CF` fraction bits. The feedback taps can therefore have an integer part while the feed-forward taps stay small fractions.

Top module: `biquad_interp`

## Requirements
- R1: A synchronous active-high `rst` clears the held input, all section delay registers, `out_sample` (to 0) and `out_valid` (to 0). With zero input after reset, every output is exactly 0.
- R2: `out_valid` is a one-cycle strobe that repeats exactly every `DIV` fast cycles, whether or not any input arrives.
- R3: Zero-order hold. When `in_valid` is high at a clock edge, `in_sample` replaces the held value, and when several strobes come in one frame the last one wins. Each frame filters the value held at its frame tick, until a new strobe arrives.
- R4: Each section computes y = round(b0*x[n] + b1*x[n-1] + b2*x[n-2] - a1*y[n-1] - a2*y[n-2]) / 2^CF. Coefficient parameters are ordered {b0, b1, b2, a1, a2} as signed integers with `CF` fraction bits. The input to the first section is the held sample times 2^SF.
- R5: The second section's input for a frame is the first section's output from the previous frame, which gives one frame of pipeline delay between the sections.
- R6: The section result is rounded once, half-up (add 2^(CF-1), then arithmetic right shift by CF), and saturated to the signed `S_W`-bit state range.
- R7: `out_sample` = (y2 + 2^(SF-1)) >>> SF, where y2 is the second section's output, saturated to the signed `OUT_W`-bit range, never wrapped. It is updated together with the `out_valid` strobe.
- R8: With the default coefficients, a constant input settles to an output within 1 LSB of that input (unity DC gain).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock (frame rate times `DIV`) |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe marking a new converter sample |
| in_sample | input | IN_W | Signed converter sample |
| out_valid | output | 1 | One-cycle strobe per frame |
| out_sample | output | OUT_W | Filtered, saturated signed output |

## Verification
A full-scale step of +32767, and then of -32768, drives the underdamped cascade past the 16-bit range. A design that wraps instead of saturating shows a jump to the opposite rail during the overshoot. Every frame of a step, a slow held sine and a zero run is compared bit for bit against an integer model. This catches a tap sign flip, a rounding applied per product instead of once, a truncation where half-up rounding belongs, and a missing one-frame delay between the sections. Bursts of two strobes inside one frame expose a hold that keeps the first value. A mid-run reset followed by zero input exposes delay registers that reset leaves dirty.

// File: rtl/biq_pkg.sv
package biq_pkg;
  localparam int TAPS = 5;
  typedef logic [2:0] tap_t;
  localparam tap_t LAST_TAP = tap_t'(TAPS - 1);
endpackage

// File: rtl/frame_timer.sv
module frame_timer #(
  parameter int DIV = 10
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] TOP = CNT_W'(DIV - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else if (cnt_q == TOP) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  assign tick = (cnt_q == TOP);
endmodule

// File: rtl/biq_section.sv
module biq_section
  import biq_pkg::*;
#(
  parameter int S_W    = 24,
  parameter int COEF_W = 18,
  parameter int CF     = 14,
  parameter int COEFS [TAPS] = '{0, 0, 0, 0, 0}
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic signed [S_W-1:0] x_in,
  output logic signed [S_W-1:0] y_out,
  output logic                  done
);
  localparam int ACC_W = S_W + COEF_W + 3;
  localparam logic signed [ACC_W-1:0] HALF =
    {{(ACC_W-CF){1'b0}}, 1'b1, {(CF-1){1'b0}}};
  localparam logic signed [ACC_W-1:0] SMAX =
    {{(ACC_W-S_W+1){1'b0}}, {(S_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] SMIN =
    {{(ACC_W-S_W+1){1'b1}}, {(S_W-1){1'b0}}};

  logic signed [S_W-1:0]    xa_q, xb_q, xc_q, ya_q, yb_q;
  logic signed [ACC_W-1:0]  acc_q;
  tap_t                     step_q;
  logic                     busy_q;

  logic signed [S_W-1:0]    opnd;
  logic signed [COEF_W-1:0] coef;
  logic signed [ACC_W-1:0]  prod, sum, rnd, ysat;

  // operand/coefficient selection for the shared multiplier
  always_comb begin
    case (step_q)
      3'd0:    begin opnd = xa_q; coef = COEF_W'(COEFS[0]); end
      3'd1:    begin opnd = xb_q; coef = COEF_W'(COEFS[1]); end
      3'd2:    begin opnd = xc_q; coef = COEF_W'(COEFS[2]); end
      3'd3:    begin opnd = ya_q; coef = COEF_W'(COEFS[3]); end
      3'd4:    begin opnd = yb_q; coef = COEF_W'(COEFS[4]); end
      default: begin opnd = '0;   coef = '0;                 end
    endcase
    prod = ACC_W'(coef) * ACC_W'(opnd);
    sum  = (step_q >= 3'd3) ? acc_q - prod : acc_q + prod;
    rnd  = (sum + HALF) >>> CF;
    if (rnd > SMAX)      ysat = SMAX;
    else if (rnd < SMIN) ysat = SMIN;
    else                 ysat = rnd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      xa_q <= '0; xb_q <= '0; xc_q <= '0;
      ya_q <= '0; yb_q <= '0;
      acc_q <= '0; step_q <= '0; busy_q <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        xa_q   <= x_in;
        acc_q  <= '0;
        step_q <= '0;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        if (step_q == LAST_TAP) begin
          ya_q   <= ysat[S_W-1:0];
          yb_q   <= ya_q;
          xb_q   <= xa_q;
          xc_q   <= xb_q;
          busy_q <= 1'b0;
          done   <= 1'b1;
        end else begin
          acc_q  <= sum;
          step_q <= step_q + 1'b1;
        end
      end
    end
  end

  assign y_out = ya_q;
endmodule

// File: rtl/biquad_interp.sv
module biquad_interp #(
  parameter int IN_W   = 16,
  parameter int OUT_W  = 16,
  parameter int S_W    = 24,
  parameter int SF     = 6,
  parameter int COEF_W = 18,
  parameter int CF     = 14,
  parameter int DIV    = 10,
  parameter int SEC0_C [5] = '{82, 164, 82, -29491, 13435},
  parameter int SEC1_C [5] = '{164, 327, 164, -27853, 12124}
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic signed [IN_W-1:0] in_sample,
  output logic                   out_valid,
  output logic signed [OUT_W-1:0] out_sample
);
  localparam int NSEC = 2;
  localparam logic signed [S_W:0] HALF_O =
    {{(S_W+1-SF){1'b0}}, 1'b1, {(SF-1){1'b0}}};
  localparam logic signed [S_W:0] OMAX =
    {{(S_W-OUT_W+2){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [S_W:0] OMIN =
    {{(S_W-OUT_W+2){1'b1}}, {(OUT_W-1){1'b0}}};

  logic signed [IN_W-1:0] hold_q;
  logic                   tick;
  logic signed [S_W-1:0]  x_scaled;
  logic signed [S_W-1:0]  y_v    [NSEC];
  logic                   done_v [NSEC];
  logic signed [S_W:0]    o_rnd;
  logic signed [OUT_W-1:0] o_sat;

  always_ff @(posedge clk) begin
    if (rst) hold_q <= '0;
    else if (in_valid) hold_q <= in_sample;
  end

  frame_timer #(.DIV(DIV)) u_timer (.clk(clk), .rst(rst), .tick(tick));

  assign x_scaled = {{(S_W-IN_W-SF){hold_q[IN_W-1]}}, hold_q, {SF{1'b0}}};

  for (genvar g = 0; g < NSEC; g++) begin : g_sec
    if (g == 0) begin : g_first
      biq_section #(.S_W(S_W), .COEF_W(COEF_W), .CF(CF), .COEFS(SEC0_C)) u_sec (
        .clk(clk), .rst(rst), .start(tick), .x_in(x_scaled),
        .y_out(y_v[g]), .done(done_v[g]));
    end else begin : g_next
      biq_section #(.S_W(S_W), .COEF_W(COEF_W), .CF(CF), .COEFS(SEC1_C)) u_sec (
        .clk(clk), .rst(rst), .start(tick), .x_in(y_v[g-1]),
        .y_out(y_v[g]), .done(done_v[g]));
    end
  end

  always_comb begin
    o_rnd = ($signed({y_v[NSEC-1][S_W-1], y_v[NSEC-1]}) + HALF_O) >>> SF;
    if (o_rnd > OMAX)      o_sat = OMAX[OUT_W-1:0];
    else if (o_rnd < OMIN) o_sat = OMIN[OUT_W-1:0];
    else                   o_sat = o_rnd[OUT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_sample <= '0;
    end else begin
      out_valid <= done_v[NSEC-1];
      if (done_v[NSEC-1]) out_sample <= o_sat;
    end
  end
endmodule

// File: rtl/biq_checker.sv
module biq_checker #(
  parameter int DIV   = 10,
  parameter int IN_W  = 16,
  parameter int OUT_W = 16
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   in_valid,
  input logic                   out_valid,
  input logic signed [OUT_W-1:0] out_sample,
  input logic signed [IN_W-1:0] hold,
  input logic                   done_a,
  input logic                   done_b
);
  logic [31:0] gap_q;
  logic        seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q <= '0; seen_q <= 1'b0;
    end else if (out_valid) begin
      gap_q <= '0; seen_q <= 1'b1;
    end else if (gap_q != 32'hFFFF_FFFF) begin
      gap_q <= gap_q + 1;
    end
  end

  // R1: reset leaves output and strobe cleared
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!out_valid && out_sample == '0));

  // R2: strobe spacing is exactly DIV cycles
  a_r2_frame_spacing: assert property (@(posedge clk) disable iff (rst)
    (out_valid && seen_q) |-> (gap_q == 32'(DIV - 1)));

  // R3: held sample moves only on a strobe
  a_r3_hold_stable: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(hold));

  // R5: both sections finish in the same cycle
  a_r5_sections_lockstep: assert property (@(posedge clk) disable iff (rst)
    done_a |-> done_b);

  // R7: output strobe follows completion of the last section
  a_r7_valid_after_done: assert property (@(posedge clk) disable iff (rst)
    done_b |=> out_valid);
endmodule

bind biquad_interp biq_checker #(.DIV(DIV), .IN_W(IN_W), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .out_valid(out_valid),
  .out_sample(out_sample), .hold(hold_q),
  .done_a(done_v[0]), .done_b(done_v[1]));

// File: tb/sim_biquad_interp.sv
`timescale 1ns/1ps
module sim_biquad_interp;
  localparam int DIV = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [15:0] in_sample = '0;
  logic out_valid;
  logic signed [15:0] out_sample;

  always #2.5 clk = ~clk;

  biquad_interp u0 (.clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
                    .out_valid(out_valid), .out_sample(out_sample));

  int checks = 0;
  int failures = 0;
  bit done_flag = 0;

  // independent integer model
  longint cf [2][5];
  longint px1 [2], px2 [2], py1 [2], py2 [2];
  longint mh;

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int g = 0; g < 2; g++) begin
      px1[g] = 0; px2[g] = 0; py1[g] = 0; py2[g] = 0;
    end
    mh = 0;
  endtask

  function automatic longint sec_step(int g, longint x);
    longint acc, y;
    acc = cf[g][0]*x + cf[g][1]*px1[g] + cf[g][2]*px2[g]
        - cf[g][3]*py1[g] - cf[g][4]*py2[g];
    y = (acc + 8192) >>> 14;
    if (y > 8388607) y = 8388607;
    if (y < -8388608) y = -8388608;
    px2[g] = px1[g]; px1[g] = x; py2[g] = py1[g]; py1[g] = y;
    return y;
  endfunction

  function automatic longint model_frame();
    longint s2in, o;
    s2in = py1[0];
    void'(sec_step(0, mh * 64));
    o = (sec_step(1, s2in) + 32) >>> 6;
    if (o > 32767) o = 32767;
    if (o < -32768) o = -32768;
    return o;
  endfunction

  task automatic wait_out();
    @(negedge clk);
    while (!out_valid) @(negedge clk);
  endtask

  // one frame: wait for strobe, compare bit-exact
  task automatic frame(string req, output longint got);
    longint e;
    wait_out();
    e = model_frame();
    got = out_sample;
    chk(req, got, e);
  endtask

  task automatic send(longint v);
    in_valid = 1'b1; in_sample = 16'(v);
    @(negedge clk);
    in_valid = 1'b0;
    mh = v;
  endtask

  initial begin
    #(5.0 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    longint got, mx, mn, last;
    int gap;
    cf[0] = '{82, 164, 82, -29491, 13435};
    cf[1] = '{164, 327, 164, -27853, 12124};
    model_reset();

    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: state right after reset
    chk("R1 out_valid after reset", out_valid, 0);
    chk("R1 out_sample after reset", out_sample, 0);

    // R1 zero input gives zero output; R2 spacing
    for (int i = 0; i < 20; i++) frame("R1 zero run", got);
    gap = 0;
    @(negedge clk);
    while (!out_valid) begin gap++; @(negedge clk); end
    void'(model_frame());
    chk("R2 strobe spacing", gap + 1, DIV);
    chk("R2 strobe width", 1, 1);
    @(negedge clk);
    chk("R2 strobe one cycle", out_valid, 0);

    // R4 R5 R6: step to 1000, bit exact every frame; R8 settle
    send(1000);
    for (int i = 0; i < 200; i++) frame("R4 R5 R6 step 1000", got);
    chk("R8 settle within 1", (got >= 999 && got <= 1001) ? 1 : 0, 1);

    // R3: two strobes in one frame, last wins
    wait_out(); chk("R3 burst frame", out_sample, model_frame());
    send(-2500);
    send(-700);
    for (int i = 0; i < 200; i++) frame("R3 burst last wins", got);
    chk("R3 R8 settle to last", (got >= -701 && got <= -699) ? 1 : 0, 1);

    // R3 R4: slow held sine, new sample every 8 frames
    for (int k = 0; k < 96; k++) begin
      send(longint'($rtoi(12000.0 * $sin(6.283185307 * k / 48.0))));
      for (int f = 0; f < 8; f++) frame("R3 R4 held sine", got);
    end

    // R7: full-scale positive step saturates at the top rail
    send(32767);
    mx = -100000;
    for (int i = 0; i < 200; i++) begin
      frame("R7 positive full scale", got);
      if (got > mx) mx = got;
    end
    chk("R7 positive rail reached", mx, 32767);
    // R7: full-scale negative step, no wrap
    send(-32768);
    mn = 100000; last = 32767;
    for (int i = 0; i < 200; i++) begin
      frame("R7 negative full scale", got);
      if (got < mn) mn = got;
      if (got > last + 20000) chk("R7 no wrap jump", got, last);
      last = got;
    end
    chk("R7 negative rail reached", mn, -32768);

    // R1: mid-run reset clears everything
    send(5000);
    for (int i = 0; i < 15; i++) frame("R4 before reset", got);
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_reset();
    chk("R1 out_valid after mid reset", out_valid, 0);
    chk("R1 out_sample after mid reset", out_sample, 0);
    for (int i = 0; i < 30; i++) frame("R1 zero after mid reset", got);
    chk("R1 final zero", got, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule